// File: doc/BRIEF.md
# E1 National-Bit Event Interrupt Monitor

This block watches the four national-use bits (Sa5 to Sa8) received in each E1 frame, together with a pulse that flags each pseudo-random test pattern error. It turns the events it detects into one active-low interrupt request. The events are a change in a single Sa bit, a change in an assembled four-frame Sa nibble, a run of identical Sa6 nibbles, a single pattern error and a wrap of the pattern error counter. Each event has its own enable bit. Every event in this group reports the same vector byte.

Software services the request by toggling an acknowledge bit. An edge in either direction clears the pending request. A suspend bit disables the request driver and discards any event that arrives while it is set. Frame alignment, extraction of the bits from the serial stream, bus decode and all other interrupt sources sit outside this block.

Top module: `e1_natbit_irq_mon`

## Requirements
- R1: `err_cnt_o` is an 8-bit count of the cycles in which `prbs_err_i` is high. It wraps from 8'hFF to 8'h00, is 0 after reset and never changes in a cycle without a pulse.
- R2: When `evt_en_i[6]` is 1, an error pulse that arrives while `err_cnt_o` is 8'hFF (the pulse that wraps the count) raises the interrupt.
- R3: When `evt_en_i[5]` is 1, every error pulse raises the interrupt.
- R4: `sa_i[0]` carries Sa5, `sa_i[1]` Sa6, `sa_i[2]` Sa7 and `sa_i[3]` Sa8. They are sampled when `frame_vld_i` is 1. When `evt_en_i[3]` is 1, a sampled value that differs from the previous frame's value in any lane raises the interrupt. When `evt_en_i[0]` is 1, only a change in the Sa5 lane does so. The first frame after reset only sets the reference.
- R5: Each lane shifts its sampled bit in at the least significant end, so the oldest of four frames is bit 3. On `nib_end_i`, the nibble is compared with the nibble from the previous `nib_end_i`; a frame sampled in that same cycle is included. When `evt_en_i[4]` is 1, a difference in any lane raises the interrupt. When `evt_en_i[1]` is 1, only a difference in the Sa6 lane does so. The first nibble after reset only sets the reference.
- R6: When `evt_en_i[2]` is 1, the eighth Sa6 nibble in a row with the same value raises the interrupt. It fires once. Further equal nibbles do not fire again. A different nibble restarts the run at a length of 1.
- R7: An event whose enable bit is 0 has no effect. `evt_en_i[7]` is reserved and has no effect.
- R8: The interrupt becomes pending in the clock cycle after a raising event, and `irq_n_o` goes low. It stays low through further events until it is acknowledged. `vec_o` reads 8'h02 while an interrupt is pending and 8'h00 otherwise.
- R9: A change of `ack_i` in either direction clears the pending interrupt on the next clock. If a raising event occurs in the same cycle, the interrupt stays pending.
- R10: While `hold_i` is 1, `irq_oe_o` is 0. Events that occur in that time are discarded and do not appear after `hold_i` returns to 0. An interrupt that was already pending is kept.
- R11: After reset, `irq_n_o` is 1, `vec_o` is 8'h00 and `err_cnt_o` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sa_i | input | 4 | Received Sa5..Sa8 bits of the current frame |
| frame_vld_i | input | 1 | `sa_i` holds a new frame's bits |
| nib_end_i | input | 1 | Four-frame nibble is complete |
| prbs_err_i | input | 1 | Single pattern error pulse |
| evt_en_i | input | 8 | Per-event enable bits |
| hold_i | input | 1 | Suspend: driver off, events discarded |
| ack_i | input | 1 | Acknowledge; either edge clears |
| irq_n_o | output | 1 | Interrupt request, active low |
| irq_oe_o | output | 1 | Driver enable for `irq_n_o` |
| vec_o | output | 8 | Interrupt vector |
| err_cnt_o | output | 8 | Pattern error count |

## Verification
A stale lane reference or a shifted nibble register only becomes visible as a missing or extra drop of `irq_n_o`, one cycle after the frame or nibble strobe that should have decided the event. The bench therefore compares the request and the vector with a reference model on every clock. A run counter that is off by one shows on the seventh or ninth equal Sa6 nibble instead of the eighth. An error counter fault shows directly on `err_cnt_o`, and as a misplaced wrap interrupt.

// File: rtl/e1nb_pkg.sv
package e1nb_pkg;

    localparam int LANES   = 4;
    localparam int NIB_W   = 4;
    localparam int RUN_LEN = 8;
    localparam int CNT_W   = 8;
    localparam int EN_W    = 8;

    localparam int LANE_SA5 = 0;
    localparam int LANE_SA6 = 1;

    // enable bit positions (software decodes these)
    localparam int EN_SA5_BIT  = 0;
    localparam int EN_SA6_NIB  = 1;
    localparam int EN_SA6_RUN  = 2;
    localparam int EN_ANY_BIT  = 3;
    localparam int EN_ANY_NIB  = 4;
    localparam int EN_PRBS_ERR = 5;
    localparam int EN_PRBS_OVF = 6;
    localparam int EN_RSVD     = 7;

    localparam logic [7:0] GROUP_VEC = 8'h02;
    localparam logic [7:0] IDLE_VEC  = 8'h00;

    typedef struct packed {
        logic sa5_bit;
        logic sa6_nib;
        logic sa6_run;
        logic any_bit;
        logic any_nib;
    } sa_evt_t;

    typedef struct packed {
        logic err;
        logic ovf;
    } prbs_evt_t;

    function automatic logic [EN_W-1:0] pack_events(sa_evt_t s, prbs_evt_t p);
        logic [EN_W-1:0] v;
        v              = '0;
        v[EN_SA5_BIT]  = s.sa5_bit;
        v[EN_SA6_NIB]  = s.sa6_nib;
        v[EN_SA6_RUN]  = s.sa6_run;
        v[EN_ANY_BIT]  = s.any_bit;
        v[EN_ANY_NIB]  = s.any_nib;
        v[EN_PRBS_ERR] = p.err;
        v[EN_PRBS_OVF] = p.ovf;
        v[EN_RSVD]     = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/e1nb_sa_lane.sv
module e1nb_sa_lane #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_vld_i,
    input  logic             bit_i,
    input  logic             nib_end_i,
    output logic             bit_chg_o,
    output logic             nib_chg_o,
    output logic [NIB_W-1:0] nib_o
);

    logic [NIB_W-1:0] shreg_q;
    logic [NIB_W-1:0] nib_ref_q;
    logic             bit_ref_q;
    logic             bit_seen_q;
    logic             nib_seen_q;
    logic [NIB_W-1:0] shifted;

    assign shifted = {shreg_q[NIB_W-2:0], bit_i};
    assign nib_o   = frame_vld_i ? shifted : shreg_q;

    assign bit_chg_o = frame_vld_i && bit_seen_q && (bit_i != bit_ref_q);
    assign nib_chg_o = nib_end_i && nib_seen_q && (nib_o != nib_ref_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q    <= '0;
            bit_ref_q  <= 1'b0;
            bit_seen_q <= 1'b0;
        end else if (frame_vld_i) begin
            shreg_q    <= shifted;
            bit_ref_q  <= bit_i;
            bit_seen_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nib_ref_q  <= '0;
            nib_seen_q <= 1'b0;
        end else if (nib_end_i) begin
            nib_ref_q  <= nib_o;
            nib_seen_q <= 1'b1;
        end
    end

endmodule

// File: rtl/e1nb_run_det.sv
module e1nb_run_det #(
    parameter int NIB_W   = 4,
    parameter int RUN_LEN = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nib_end_i,
    input  logic [NIB_W-1:0] nib_i,
    output logic             hit_o
);

    localparam int RW = $clog2(RUN_LEN + 1);
    localparam logic [RW-1:0] FULL    = RW'(RUN_LEN);
    localparam logic [RW-1:0] PRE_HIT = RW'(RUN_LEN - 1);
    localparam logic [RW-1:0] ONE     = RW'(1);

    logic [NIB_W-1:0] last_q;
    logic             seen_q;
    logic [RW-1:0]    len_q;
    logic             same;

    assign same  = seen_q && (nib_i == last_q);
    assign hit_o = nib_end_i && same && (len_q == PRE_HIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
            seen_q <= 1'b0;
            len_q  <= '0;
        end else if (nib_end_i) begin
            last_q <= nib_i;
            seen_q <= 1'b1;
            if (!same) begin
                len_q <= ONE;
            end else if (len_q != FULL) begin
                len_q <= len_q + ONE;
            end
        end
    end

endmodule

// File: rtl/e1nb_err_cnt.sv
module e1nb_err_cnt #(
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 err_i,
    output e1nb_pkg::prbs_evt_t  evt_o,
    output logic [CNT_W-1:0]     cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    assign evt_o.err = err_i;
    assign evt_o.ovf = err_i && (&cnt_q);
    assign cnt_o     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (err_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/e1nb_irq_ctrl.sv
module e1nb_irq_ctrl #(
    parameter int EN_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [EN_W-1:0] evt_i,
    input  logic [EN_W-1:0] en_i,
    input  logic            hold_i,
    input  logic            ack_i,
    output logic            raise_o,
    output logic            irq_n_o,
    output logic            irq_oe_o,
    output logic [7:0]      vec_o
);

    logic pend_q;
    logic ack_q;
    logic ack_edge;

    assign raise_o  = !hold_i && (|(evt_i & en_i));
    assign ack_edge = ack_i ^ ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            ack_q  <= 1'b0;
        end else begin
            ack_q <= ack_i;
            if (raise_o) begin
                pend_q <= 1'b1;
            end else if (ack_edge) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign irq_n_o  = !pend_q;
    assign irq_oe_o = !hold_i;
    assign vec_o    = pend_q ? e1nb_pkg::GROUP_VEC : e1nb_pkg::IDLE_VEC;

endmodule

// File: rtl/e1_natbit_irq_mon.sv
module e1_natbit_irq_mon
    import e1nb_pkg::*;
#(
    parameter int N_LANE = LANES,
    parameter int NW     = NIB_W,
    parameter int RUN    = RUN_LEN,
    parameter int CW     = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_LANE-1:0] sa_i,
    input  logic              frame_vld_i,
    input  logic              nib_end_i,
    input  logic              prbs_err_i,
    input  logic [EN_W-1:0]   evt_en_i,
    input  logic              hold_i,
    input  logic              ack_i,
    output logic              irq_n_o,
    output logic              irq_oe_o,
    output logic [7:0]        vec_o,
    output logic [CW-1:0]     err_cnt_o
);

    logic [N_LANE-1:0] bit_chg;
    logic [N_LANE-1:0] nib_chg;
    logic [NW-1:0]     lane_nib [N_LANE];
    logic              run_hit;
    sa_evt_t           sa_evt;
    prbs_evt_t         prbs_evt;
    logic [EN_W-1:0]   evt_vec;
    logic              irq_raise;

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        e1nb_sa_lane #(.NIB_W(NW)) u_lane (
            .clk        (clk),
            .rst        (rst),
            .frame_vld_i(frame_vld_i),
            .bit_i      (sa_i[g]),
            .nib_end_i  (nib_end_i),
            .bit_chg_o  (bit_chg[g]),
            .nib_chg_o  (nib_chg[g]),
            .nib_o      (lane_nib[g])
        );
    end

    e1nb_run_det #(.NIB_W(NW), .RUN_LEN(RUN)) u_run (
        .clk      (clk),
        .rst      (rst),
        .nib_end_i(nib_end_i),
        .nib_i    (lane_nib[LANE_SA6]),
        .hit_o    (run_hit)
    );

    e1nb_err_cnt #(.CNT_W(CW)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .err_i(prbs_err_i),
        .evt_o(prbs_evt),
        .cnt_o(err_cnt_o)
    );

    always_comb begin
        sa_evt.sa5_bit = bit_chg[LANE_SA5];
        sa_evt.sa6_nib = nib_chg[LANE_SA6];
        sa_evt.sa6_run = run_hit;
        sa_evt.any_bit = |bit_chg;
        sa_evt.any_nib = |nib_chg;
    end

    assign evt_vec = pack_events(sa_evt, prbs_evt);

    e1nb_irq_ctrl #(.EN_W(EN_W)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt_vec),
        .en_i    (evt_en_i),
        .hold_i  (hold_i),
        .ack_i   (ack_i),
        .raise_o (irq_raise),
        .irq_n_o (irq_n_o),
        .irq_oe_o(irq_oe_o),
        .vec_o   (vec_o)
    );

endmodule

// File: rtl/e1nb_checker.sv
module e1nb_checker (
    input logic       clk,
    input logic       rst,
    input logic       prbs_err_i,
    input logic [7:0] evt_en_i,
    input logic       hold_i,
    input logic       ack_i,
    input logic       irq_n_o,
    input logic [7:0] vec_o,
    input logic [7:0] err_cnt_o,
    input logic       irq_raise
);

    logic ack_seen;
    logic ack_edge;

    always_ff @(posedge clk) begin
        if (rst) ack_seen <= 1'b0;
        else     ack_seen <= ack_i;
    end
    assign ack_edge = ack_i != ack_seen;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        prbs_err_i |=> err_cnt_o == $past(err_cnt_o) + 8'd1); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !prbs_err_i |=> $stable(err_cnt_o)); // R1
    AST_WRAP_RAISE: assert property (@(posedge clk) disable iff (rst)
        (prbs_err_i && err_cnt_o == 8'hFF && evt_en_i[6] && !hold_i) |=> !irq_n_o); // R2
    AST_ERR_RAISE: assert property (@(posedge clk) disable iff (rst)
        (prbs_err_i && evt_en_i[5] && !hold_i) |=> !irq_n_o); // R3
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (evt_en_i[6:0] == 7'd0) |-> !irq_raise); // R7
    AST_PEND_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!irq_n_o && !ack_edge) |=> !irq_n_o); // R8
    AST_VEC_MATCH: assert property (@(posedge clk) disable iff (rst)
        vec_o == (irq_n_o ? 8'h00 : 8'h02)); // R8
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ack_edge && !irq_raise) |=> irq_n_o); // R9
    AST_ACK_RACE: assert property (@(posedge clk) disable iff (rst)
        (ack_edge && irq_raise) |=> !irq_n_o); // R9
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (hold_i && irq_n_o) |=> irq_n_o); // R10

endmodule

bind e1_natbit_irq_mon e1nb_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .prbs_err_i(prbs_err_i),
    .evt_en_i  (evt_en_i),
    .hold_i    (hold_i),
    .ack_i     (ack_i),
    .irq_n_o   (irq_n_o),
    .vec_o     (vec_o),
    .err_cnt_o (err_cnt_o),
    .irq_raise (irq_raise)
);

// File: tb/e1_natbit_irq_mon_bench.sv
module e1_natbit_irq_mon_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] sa_i = '0;
    logic       frame_vld_i = 1'b0;
    logic       nib_end_i = 1'b0;
    logic       prbs_err_i = 1'b0;
    logic [7:0] evt_en_i = '0;
    logic       hold_i = 1'b0;
    logic       ack_i = 1'b0;
    logic       irq_n_o, irq_oe_o;
    logic [7:0] vec_o, err_cnt_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    e1_natbit_irq_mon u_e1_natbit_irq_mon (
        .clk(clk), .rst(rst), .sa_i(sa_i), .frame_vld_i(frame_vld_i),
        .nib_end_i(nib_end_i), .prbs_err_i(prbs_err_i), .evt_en_i(evt_en_i),
        .hold_i(hold_i), .ack_i(ack_i), .irq_n_o(irq_n_o), .irq_oe_o(irq_oe_o),
        .vec_o(vec_o), .err_cnt_o(err_cnt_o)
    );

    // ---------------- behavioural reference model ----------------
    int m_cnt, m_pend, m_ack, m_bseen, m_nseen, m_run;
    int m_sr[4], m_prev[4], m_ref[4];

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_pend = 0; m_ack = 0; m_bseen = 0; m_nseen = 0; m_run = 0;
            for (int k = 0; k < 4; k++) begin m_sr[k] = 0; m_prev[k] = 0; m_ref[k] = 0; end
        end else begin
            int now[4];
            bit e_sa5, e_anyb, e_sa6n, e_anyn, e_run, e_err, e_ovf, raise, tog;
            e_sa5 = 0; e_anyb = 0; e_sa6n = 0; e_anyn = 0; e_run = 0;
            for (int k = 0; k < 4; k++) begin
                now[k] = m_sr[k];
                if (frame_vld_i) begin
                    if (m_bseen != 0 && int'(sa_i[k]) != m_prev[k]) begin
                        e_anyb = 1;
                        if (k == 0) e_sa5 = 1;
                    end
                    now[k] = ((m_sr[k] * 2) + int'(sa_i[k])) % 16;
                end
            end
            if (nib_end_i) begin
                if (m_nseen != 0 && now[1] == m_ref[1]) begin
                    if (m_run < 8) begin
                        m_run++;
                        if (m_run == 8) e_run = 1;
                    end
                end else m_run = 1;
                for (int k = 0; k < 4; k++)
                    if (m_nseen != 0 && now[k] != m_ref[k]) begin
                        e_anyn = 1;
                        if (k == 1) e_sa6n = 1;
                    end
                for (int k = 0; k < 4; k++) m_ref[k] = now[k];
                m_nseen = 1;
            end
            if (frame_vld_i) begin
                for (int k = 0; k < 4; k++) begin m_sr[k] = now[k]; m_prev[k] = int'(sa_i[k]); end
                m_bseen = 1;
            end
            e_err = prbs_err_i;
            e_ovf = prbs_err_i && m_cnt == 255;
            if (prbs_err_i) m_cnt = (m_cnt + 1) % 256;
            raise = !hold_i && ((evt_en_i[0] && e_sa5) || (evt_en_i[1] && e_sa6n) ||
                    (evt_en_i[2] && e_run) || (evt_en_i[3] && e_anyb) ||
                    (evt_en_i[4] && e_anyn) || (evt_en_i[5] && e_err) ||
                    (evt_en_i[6] && e_ovf));
            tog = int'(ack_i) != m_ack;
            m_ack = int'(ack_i);
            if (raise) m_pend = 1;
            else if (tog) m_pend = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the edges
    always begin
        @(negedge clk);
        #1;
        if (!done) begin
            chk(irq_n_o == (m_pend == 0), "R8 irq_n vs model", int'(irq_n_o), int'(m_pend == 0));
            chk(vec_o == (m_pend != 0 ? 8'h02 : 8'h00), "R8 vector vs model", int'(vec_o), m_pend != 0 ? 2 : 0);
            chk(int'(err_cnt_o) == m_cnt, "R1 count vs model", int'(err_cnt_o), m_cnt);
            chk(irq_oe_o == !hold_i, "R10 driver enable", int'(irq_oe_o), int'(!hold_i));
        end
    end

    // ---------------- stimulus helpers (start and end at a negedge) ----------------
    task automatic frame(input logic [3:0] b);
        sa_i = b; frame_vld_i = 1'b1;
        @(negedge clk);
        frame_vld_i = 1'b0;
    endtask

    task automatic send_nib(input logic [3:0] n5, n6, n7, n8, input bit merged);
        for (int i = 3; i >= 0; i--) begin
            sa_i = {n8[i], n7[i], n6[i], n5[i]};
            frame_vld_i = 1'b1;
            if (i == 0 && merged) nib_end_i = 1'b1;
            @(negedge clk);
            frame_vld_i = 1'b0;
            nib_end_i = 1'b0;
        end
        if (!merged) begin
            nib_end_i = 1'b1;
            @(negedge clk);
            nib_end_i = 1'b0;
        end
    endtask

    task automatic perr();
        prbs_err_i = 1'b1;
        @(negedge clk);
        prbs_err_i = 1'b0;
    endtask

    task automatic do_ack();
        ack_i = ~ack_i;
        @(negedge clk);
    endtask

    task automatic expect_irq(input bit low, input string tag);
        #1;
        chk(irq_n_o == !low, tag, int'(irq_n_o), int'(!low));
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(irq_n_o == 1'b1, "R11 reset irq_n", int'(irq_n_o), 1);
        chk(vec_o == 8'h00, "R11 reset vector", int'(vec_o), 0);
        chk(err_cnt_o == 8'h00, "R11 reset count", int'(err_cnt_o), 0);
        @(negedge clk);

        // R7: everything disabled
        evt_en_i = 8'h00;
        frame(4'b1111); frame(4'b0101); perr(); frame(4'b0000);
        expect_irq(0, "R7 disabled events stay quiet");

        // R4: any-bit change
        evt_en_i = 8'h08;
        frame(4'b0000);
        expect_irq(0, "R4 unchanged bits");
        frame(4'b0100);
        expect_irq(1, "R4 Sa7 change raises");
        frame(4'b0000);
        expect_irq(1, "R8 further event keeps pending");
        do_ack();
        expect_irq(0, "R9 rising ack clears");

        // R4: Sa5-only
        evt_en_i = 8'h01;
        frame(4'b0100);
        expect_irq(0, "R4 Sa7 change ignored by Sa5 enable");
        frame(4'b0101);
        expect_irq(1, "R4 Sa5 change raises");
        do_ack();
        expect_irq(0, "R9 falling ack clears");

        // R5: nibbles, Sa6 only
        evt_en_i = 8'h02;
        send_nib(4'h1, 4'h2, 4'h3, 4'h4, 0);
        expect_irq(0, "R5 first nibble is reference");
        send_nib(4'h1, 4'h2, 4'h3, 4'h4, 0);
        expect_irq(0, "R5 same nibble");
        send_nib(4'h1, 4'h2, 4'hC, 4'h4, 0);
        expect_irq(0, "R5 Sa7 nibble ignored by Sa6 enable");
        send_nib(4'h1, 4'h6, 4'hC, 4'h4, 0);
        expect_irq(1, "R5 Sa6 nibble change raises");
        do_ack();
        evt_en_i = 8'h10;
        send_nib(4'h1, 4'h6, 4'hC, 4'h9, 1);
        expect_irq(1, "R5 Sa8 change with merged strobe");
        do_ack();
        send_nib(4'h1, 4'h6, 4'hC, 4'h9, 1);
        expect_irq(0, "R5 merged strobe same nibble");

        // R6: eight equal Sa6 nibbles
        evt_en_i = 8'h04;
        send_nib(4'h0, 4'h3, 4'h0, 4'h0, 0);
        for (int n = 1; n <= 7; n++) send_nib(4'h0, 4'hA, 4'h0, 4'h0, 0);
        expect_irq(0, "R6 seventh equal nibble quiet");
        send_nib(4'h0, 4'hA, 4'h0, 4'h0, 0);
        expect_irq(1, "R6 eighth equal nibble raises");
        do_ack();
        send_nib(4'h0, 4'hA, 4'h0, 4'h0, 0);
        expect_irq(0, "R6 ninth equal nibble does not refire");
        send_nib(4'h0, 4'h3, 4'h0, 4'h0, 0);
        for (int n = 1; n <= 7; n++) send_nib(4'h0, 4'hA, 4'h0, 4'h0, 0);
        expect_irq(0, "R6 restarted run at seven");
        send_nib(4'h0, 4'hA, 4'h0, 4'h0, 0);
        expect_irq(1, "R6 restarted run at eight");
        do_ack();

        // R3 and R2: pattern errors
        evt_en_i = 8'h20;
        perr();
        expect_irq(1, "R3 single error raises");
        do_ack();
        evt_en_i = 8'h40;
        while (err_cnt_o != 8'hFF) begin
            perr();
            #1;
            chk(irq_n_o == 1'b1, "R2 no interrupt before wrap", int'(irq_n_o), 1);
            @(negedge clk);
        end
        perr();
        #1;
        chk(err_cnt_o == 8'h00, "R1 count wraps to zero", int'(err_cnt_o), 0);
        expect_irq(1, "R2 wrap raises");
        do_ack();

        // R10: suspend
        evt_en_i = 8'h08;
        hold_i = 1'b1;
        #1;
        chk(irq_oe_o == 1'b0, "R10 driver off in suspend", int'(irq_oe_o), 0);
        @(negedge clk);
        frame(4'b1101);
        expect_irq(0, "R10 event in suspend discarded");
        hold_i = 1'b0;
        @(negedge clk);
        expect_irq(0, "R10 discarded event not replayed");
        frame(4'b0101);
        expect_irq(1, "R10 event after suspend raises");
        hold_i = 1'b1;
        @(negedge clk);
        expect_irq(1, "R10 pending kept in suspend");
        hold_i = 1'b0;
        do_ack();

        // R7: reserved enable bit
        evt_en_i = 8'h80;
        frame(4'b1010); perr();
        send_nib(4'h5, 4'h5, 4'h5, 4'h5, 0);
        expect_irq(0, "R7 reserved enable has no effect");

        // R9: acknowledge and event in the same cycle
        evt_en_i = 8'h08;
        frame(4'b0000);
        expect_irq(1, "R4 change raises before race");
        sa_i = 4'b1000; frame_vld_i = 1'b1; ack_i = ~ack_i;
        @(negedge clk);
        frame_vld_i = 1'b0;
        expect_irq(1, "R9 event wins over ack");
        do_ack();
        expect_irq(0, "R9 ack alone clears");

        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule